// File: doc/BRIEF.md
# Configuration Header and Base Address Decoder

This block holds the part of a single-function bus device's configuration header that an external host uses to place the device in its memory map. It keeps two memory base registers. The first places the local SDRAM window, whose size is a parameter. The second places a fixed 2 MB aperture for memory-mapped I/O. For any bus address presented on its input, the block reports whether that address falls in either window. The header type and self-test words of the header are constant, because the device has one function, is not a bridge and has no built-in test.

A host reads and writes the header through a word-indexed configuration port. Reads are combinational, and a write takes effect at the next rising clock edge. A device that starts on its own can instead receive both base values from its boot source through a preload port. A strap input selects this behaviour, and a small boot sequencer handles it. It has four states. `ST_STRAP` samples the strap in the first cycle after reset. `ST_LOAD_SDRAM` waits for the first preload word. `ST_LOAD_MMIO` waits for the second preload word. `ST_RUN` ignores the preload port. Its transitions are:
- `T_STRAP_BOOT`: from `ST_STRAP` to `ST_LOAD_SDRAM` when the strap is high.
- `T_STRAP_SKIP`: from `ST_STRAP` to `ST_RUN` when the strap is low.
- `T_SDRAM_TAKEN`: from `ST_LOAD_SDRAM` to `ST_LOAD_MMIO` on a preload strobe.
- `T_MMIO_TAKEN`: from `ST_LOAD_MMIO` to `ST_RUN` on a preload strobe.

Top module: `cfg_hdr_bar`

## Requirements
- R1: After reset, word index 4 (SDRAM base) reads 0x00000000 and word index 5 (I/O aperture base) reads 0xEFE00000.
- R2: The I/O aperture base keeps only bits 31:21. Bits 20:0 always read 0, so writing 0xFFFFFFFF to word 5 reads back 0xFFE00000.
- R3: The SDRAM base keeps only the bits at and above SDRAM_LOG2 (default 24). Writing 0xFFFFFFFF to word 4 reads back 0xFF000000 with the default.
- R4: Word index 3 always reads 0, including after a write of 0xFFFFFFFF. That word holds the self-test byte in bits 31:24, the multi-function flag in bit 23 and the layout field in bits 22:16.
- R5: Any word index other than 4 and 5 reads 0. A write to such an index changes neither base register.
- R6: When the strap is high in the first cycle after reset, the first preload strobe loads the SDRAM base and the second loads the I/O base, both masked as in R2 and R3. Any later preload strobe is ignored.
- R7: When the strap is low in the first cycle after reset, all preload strobes are ignored.
- R8: When a preload load and a configuration write reach the same base register in the same cycle, the preload value is stored. A configuration write to the other register in that cycle still takes effect.
- R9: `sdram_hit` is high when the address bits at and above SDRAM_LOG2 equal the SDRAM base and the address is not in the I/O aperture.
- R10: `mmio_hit` is high when address bits 31:21 equal the I/O base.
- R11: When an address lies in both windows, only `mmio_hit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_standalone | input | 1 | Strap that selects the preload boot sequence |
| cfg_addr | input | 6 | Configuration word index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| pre_valid | input | 1 | Preload strobe from the boot source |
| pre_data | input | 32 | Preload base value |
| bus_addr | input | 32 | Bus address to decode |
| sdram_hit | output | 1 | Address falls in the SDRAM window |
| mmio_hit | output | 1 | Address falls in the I/O aperture |

## Verification
Two functions can meet in one cycle: a boot preload load and a host configuration write. The bench provokes this during the boot sequence. In `ST_LOAD_SDRAM` it strobes a preload word together with a write of a different value to word 4. In `ST_LOAD_MMIO` it strobes a preload word together with a write to word 4. The collision is judged by reading back both base registers: the first register must hold the preload value, and the second case must store both values. The decoder priority is also checked at an overlap, by moving the SDRAM window over the I/O aperture.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
    localparam int CFG_AW   = 6;
    localparam int DATA_W   = 32;
    localparam int MMIO_LOG2 = 21;

    localparam logic [CFG_AW-1:0] IDX_HDR   = 6'd3;
    localparam logic [CFG_AW-1:0] IDX_SDRAM = 6'd4;
    localparam logic [CFG_AW-1:0] IDX_MMIO  = 6'd5;

    localparam logic [DATA_W-1:0] SDRAM_RESET = 32'h0000_0000;
    localparam logic [DATA_W-1:0] MMIO_RESET  = 32'hEFE0_0000;

    typedef enum logic [1:0] {
        ST_STRAP      = 2'd0,
        ST_LOAD_SDRAM = 2'd1,
        ST_LOAD_MMIO  = 2'd2,
        ST_RUN        = 2'd3
    } boot_state_e;

    function automatic logic [DATA_W-1:0] size_mask(input int log2);
        return ~((32'd1 << log2) - 32'd1);
    endfunction
endpackage

// File: rtl/cfg_boot_fsm.sv
module cfg_boot_fsm
    import cfg_hdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic pre_valid,
    output logic load_sdram,
    output logic load_mmio
);
    boot_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STRAP;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STRAP:      state_nx = strap ? ST_LOAD_SDRAM : ST_RUN;  // T_STRAP_BOOT / T_STRAP_SKIP
            ST_LOAD_SDRAM: if (pre_valid) state_nx = ST_LOAD_MMIO;     // T_SDRAM_TAKEN
            ST_LOAD_MMIO:  if (pre_valid) state_nx = ST_RUN;           // T_MMIO_TAKEN
            ST_RUN:        state_nx = ST_RUN;
            default:       state_nx = ST_STRAP;
        endcase
    end

    always_comb begin
        load_sdram = 1'b0;
        load_mmio  = 1'b0;
        unique case (state)
            ST_LOAD_SDRAM: load_sdram = pre_valid;
            ST_LOAD_MMIO:  load_mmio  = pre_valid;
            default: ;
        endcase
    end

    p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_sdram, load_mmio}));
    p_run_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !(load_sdram || load_mmio));
    p_skip_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRAP && !strap) |=> (state == ST_RUN));
endmodule

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
    import cfg_hdr_pkg::*;
#(
    parameter int                SIZE_LOG2 = 21,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pre_we,
    input  logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] base
);
    localparam logic [DATA_W-1:0] MASK = size_mask(SIZE_LOG2);

    always_ff @(posedge clk) begin
        if (!rst_n)      base <= RESET_VAL & MASK;
        else if (pre_we) base <= pre_data & MASK;
        else if (cfg_we) base <= cfg_wdata & MASK;
    end

    p_low_clear_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (base & ~MASK) == '0);
    p_preload_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_we && cfg_we) |=> (base == ($past(pre_data) & MASK)));
endmodule

// File: rtl/cfg_bar_decode.sv
module cfg_bar_decode
    import cfg_hdr_pkg::*;
#(
    parameter int SDRAM_LOG2 = 24
) (
    input  logic [DATA_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] sdram_base,
    input  logic [DATA_W-1:0] mmio_base,
    output logic              sdram_hit,
    output logic              mmio_hit
);
    localparam logic [DATA_W-1:0] SD_MASK = size_mask(SDRAM_LOG2);
    localparam logic [DATA_W-1:0] IO_MASK = size_mask(MMIO_LOG2);

    logic sd_match, io_match;

    always_comb begin
        sd_match  = ((bus_addr ^ sdram_base) & SD_MASK) == '0;
        io_match  = ((bus_addr ^ mmio_base)  & IO_MASK) == '0;
        mmio_hit  = io_match;
        sdram_hit = sd_match && !io_match;
    end
endmodule

// File: rtl/cfg_hdr_bar.sv
module cfg_hdr_bar
    import cfg_hdr_pkg::*;
#(
    parameter int SDRAM_LOG2 = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_standalone,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              pre_valid,
    input  logic [DATA_W-1:0] pre_data,
    input  logic [DATA_W-1:0] bus_addr,
    output logic              sdram_hit,
    output logic              mmio_hit
);
    logic              load_sdram, load_mmio;
    logic              we_sdram, we_mmio;
    logic [DATA_W-1:0] sdram_base, mmio_base;

    assign we_sdram = cfg_we && (cfg_addr == IDX_SDRAM);
    assign we_mmio  = cfg_we && (cfg_addr == IDX_MMIO);

    cfg_boot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (boot_standalone),
        .pre_valid  (pre_valid),
        .load_sdram (load_sdram),
        .load_mmio  (load_mmio)
    );

    cfg_bar_reg #(.SIZE_LOG2(SDRAM_LOG2), .RESET_VAL(SDRAM_RESET)) u_sdram_bar (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (we_sdram),
        .cfg_wdata (cfg_wdata),
        .pre_we    (load_sdram),
        .pre_data  (pre_data),
        .base      (sdram_base)
    );

    cfg_bar_reg #(.SIZE_LOG2(MMIO_LOG2), .RESET_VAL(MMIO_RESET)) u_mmio_bar (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (we_mmio),
        .cfg_wdata (cfg_wdata),
        .pre_we    (load_mmio),
        .pre_data  (pre_data),
        .base      (mmio_base)
    );

    cfg_bar_decode #(.SDRAM_LOG2(SDRAM_LOG2)) u_dec (
        .bus_addr   (bus_addr),
        .sdram_base (sdram_base),
        .mmio_base  (mmio_base),
        .sdram_hit  (sdram_hit),
        .mmio_hit   (mmio_hit)
    );

    // Header word: self-test, single-function flag and non-bridge layout all zero.
    always_comb begin
        unique case (cfg_addr)
            IDX_SDRAM: cfg_rdata = sdram_base;
            IDX_MMIO:  cfg_rdata = mmio_base;
            default:   cfg_rdata = '0;
        endcase
    end

    p_exclusive_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdram_hit && mmio_hit));
    p_io_bar_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != IDX_MMIO && !load_mmio) |=> $stable(mmio_base));
endmodule

// File: tb/tb_cfg_hdr_bar.sv
module tb_cfg_hdr_bar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_standalone = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pre_valid = 1'b0;
    logic [31:0] pre_data = '0;
    logic [31:0] bus_addr = '0;
    logic        sdram_hit, mmio_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_hdr_bar dut (.*);

    // {address, expected sdram_hit, expected mmio_hit} with reset bases
    localparam bit [33:0] VEC [0:6] = '{
        {32'h0000_0000, 1'b1, 1'b0},
        {32'h00FF_FFFF, 1'b1, 1'b0},
        {32'h0100_0000, 1'b0, 1'b0},
        {32'hEFE0_0000, 1'b0, 1'b1},
        {32'hEFFF_FFFF, 1'b0, 1'b1},
        {32'hEFDF_FFFF, 1'b0, 1'b0},
        {32'hF000_0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [5:0] idx, input logic [31:0] wd,
                        input logic pv, input logic [31:0] pd);
        @(negedge clk);
        cfg_we = we; cfg_addr = idx; cfg_wdata = wd; pre_valid = pv; pre_data = pd;
        @(negedge clk);
        cfg_we = 1'b0; pre_valid = 1'b0;
    endtask

    task automatic rd(input string req, input logic [5:0] idx, input logic [31:0] exp);
        cfg_addr = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic hits(input string req, input logic [31:0] a, input logic sh, input logic mh);
        bus_addr = a;
        #1;
        check(req, {30'd0, sdram_hit, mmio_hit}, {30'd0, sh, mh});
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; boot_standalone = strap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);   // ST_STRAP resolved at the edge before this point
    endtask

    initial begin
        do_reset(1'b0);
        rd("R1", 6'd4, 32'h0000_0000);
        rd("R1", 6'd5, 32'hEFE0_0000);
        rd("R4", 6'd3, 32'h0000_0000);

        foreach (VEC[i]) hits((VEC[i][1:0] == 2'b01) ? "R10" : "R9",
                              VEC[i][33:2], VEC[i][1], VEC[i][0]);

        step(1'b1, 6'd3, 32'hFFFF_FFFF, 1'b0, '0);
        rd("R4", 6'd3, 32'h0000_0000);
        step(1'b1, 6'd6, 32'hFFFF_FFFF, 1'b0, '0);
        rd("R5", 6'd6, 32'h0000_0000);
        rd("R5", 6'd5, 32'hEFE0_0000);
        rd("R5", 6'd4, 32'h0000_0000);

        step(1'b1, 6'd5, 32'hFFFF_FFFF, 1'b0, '0);
        rd("R2", 6'd5, 32'hFFE0_0000);
        step(1'b1, 6'd4, 32'hFFFF_FFFF, 1'b0, '0);
        rd("R3", 6'd4, 32'hFF00_0000);

        step(1'b1, 6'd5, 32'hEFE0_0000, 1'b0, '0);
        step(1'b1, 6'd4, 32'hEF12_3456, 1'b0, '0);
        rd("R3", 6'd4, 32'hEF00_0000);
        hits("R11", 32'hEFE0_0004, 1'b0, 1'b1);
        hits("R9",  32'hEF10_0000, 1'b1, 1'b0);

        step(1'b0, 6'd4, '0, 1'b1, 32'h7700_0000);
        rd("R7", 6'd4, 32'hEF00_0000);
        rd("R7", 6'd5, 32'hEFE0_0000);

        do_reset(1'b1);
        step(1'b1, 6'd4, 32'h1200_0000, 1'b1, 32'h3400_0000);
        rd("R8", 6'd4, 32'h3400_0000);
        rd("R6", 6'd5, 32'hEFE0_0000);
        step(1'b1, 6'd4, 32'h5600_0000, 1'b1, 32'h8012_3456);
        rd("R6", 6'd5, 32'h8000_0000);
        rd("R8", 6'd4, 32'h5600_0000);
        step(1'b0, 6'd0, '0, 1'b1, 32'h1111_1111);
        rd("R6", 6'd5, 32'h8000_0000);
        rd("R6", 6'd4, 32'h5600_0000);
        hits("R10", 32'h801F_FFFF, 1'b0, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule